// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit services one instruction-cache miss at a time. It takes the address that missed and issues one word request per cycle to memory. The first request is for the word that missed. The following requests walk forward through the rest of the eight-word line and wrap back to the line's start. Returning words land in a two-entry queue. The first word out of the queue is the missed word, and it is offered straight to the core. The remaining words drain into a line buffer, each at its own offset. When all eight words have arrived, the buffer is written into the cache array in one cycle, together with a parity bit per word and a line-valid bit.

When the cache is off at the moment a miss is accepted, the unit fetches only the missed word and hands it to the core. Nothing is written to the array. Tag lookup and victim selection sit outside this block. The array port carries the line-aligned address so that the surrounding logic can steer the write.

Top module: `line_fill_unit`

## Requirements
- R1: With the cache on, a fill issues exactly eight requests. Request k (k = 0..7) carries the line base address with word-offset field bits [4:2] equal to (c + k) mod 8, where c is bits [4:2] of the miss address, and bits [1:0] equal to zero.
- R2: The first response is offered on the core port as the missed word. While core_ready is low, core_valid and core_data hold steady. Exactly one word per miss is handed to the core.
- R3: The response queue holds at most two words. While the missed word waits for the core and two responses have been accepted, mem_rsp_ready is low. Before two responses are held, it is high.
- R4: After the eighth response, arr_we pulses for one cycle. Word i of the line sits in arr_data bits [32i+31:32i], and arr_addr is the miss address with bits [4:0] cleared.
- R5: arr_parity bit i is the even-parity bit of word i, equal to the XOR of its 32 bits, so that the word and its bit together hold an even count of ones.
- R6: arr_valid is high together with arr_we. There is exactly one array write per fill with the cache on, and the unit is idle in the cycle after it.
- R7: A miss accepted while cache_en is 0 issues exactly one request, for the missed word, and never writes the array. Changes to cache_en after acceptance have no effect on a fill.
- R8: miss_ready is low from the cycle after a miss is accepted until the fill ends. A miss presented meanwhile is ignored: no request for it is issued.
- R9: After reset, miss_ready is 1 and mem_req_valid, core_valid and arr_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Cache enable, sampled when a miss is accepted |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address that missed |
| miss_ready | output | 1 | Unit idle and able to accept a miss |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned request address |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_ready | output | 1 | Queue has room for a response |
| mem_rsp_data | input | 32 | Response word, in request order |
| core_valid | output | 1 | Missed word offered to the core |
| core_ready | input | 1 | Core takes the word |
| core_data | output | 32 | Missed word |
| arr_we | output | 1 | Cache-array line write |
| arr_addr | output | 32 | Line-aligned address of the written line |
| arr_data | output | 256 | Eight words, word i at bits [32i+31:32i] |
| arr_parity | output | 8 | Even-parity bit per word |
| arr_valid | output | 1 | Line-valid bit written with the line |

## Verification
The early forward of the missed word to the core can fall in the same cycle as a further response entering the queue. It can also fall in a cycle where the queue is full and memory keeps offering data. The bench provokes both by holding core_ready low for several cycles while memory keeps responding. It then checks that the queue stops accepting at two words and that the waiting word stays stable. After the core is released, it checks that the full line still arrives at the array in the right order. This is swept over every critical offset, with the cache both on and off, under three request and response rhythms. Each word's expected value and parity are computed from its address.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

    typedef enum logic [1:0] {
        LFU_IDLE  = 2'd0,
        LFU_FILL  = 2'd1,
        LFU_WRITE = 2'd2
    } lfu_state_e;

    typedef struct packed {
        logic single;
        logic busy;
    } lfu_mode_t;

    // even-parity bit: XOR of all bits of a word (up to 64 bits, zero extended)
    function automatic logic lfu_even_par(input logic [63:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/lfu_fifo2.sv
module lfu_fifo2 #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    input  logic             pop,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             push, do_pop;

    assign in_ready  = (cnt != CNT_W'(DEPTH));
    assign out_valid = (cnt != '0);
    assign out_data  = mem[rd_ptr];
    assign push      = in_valid && in_ready;
    assign do_pop    = pop && out_valid;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= in_data;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            case ({push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3
    fifo_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !do_pop) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R3
    fifo_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !push) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

endmodule

// File: rtl/lfu_line_buf.sv
module lfu_line_buf #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [$clog2(LINE_WORDS)-1:0] ofs,
    input  logic [WORD_W-1:0]            wdata,
    output logic [LINE_WORDS*WORD_W-1:0] line_data,
    output logic [LINE_WORDS-1:0]        line_par
);
    localparam int unsigned OFS_W = $clog2(LINE_WORDS);

    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (we && ofs == OFS_W'(i)) word_q <= wdata;
        end
        assign line_data[i*WORD_W +: WORD_W] = word_q;
        assign line_par[i] = lfu_pkg::lfu_even_par(64'(word_q));
    end

endmodule

// File: rtl/lfu_ctrl.sv
module lfu_ctrl
    import lfu_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cache_en,
    input  logic                          miss_valid,
    input  logic [ADDR_W-1:0]             miss_addr,
    output logic                          miss_ready,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          q_valid,
    output logic                          q_pop,
    output logic                          core_valid,
    input  logic                          core_ready,
    output logic                          buf_we,
    output logic [$clog2(LINE_WORDS)-1:0] buf_ofs,
    output logic                          arr_we,
    output logic [ADDR_W-1:0]             line_addr
);
    localparam int unsigned OFS_W  = $clog2(LINE_WORDS);
    localparam int unsigned BYTE_W = $clog2(WORD_W / 8);
    localparam int unsigned LOW_W  = OFS_W + BYTE_W;
    localparam int unsigned CNT_W  = OFS_W + 1;

    lfu_state_e       state;
    lfu_mode_t        mode;
    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0] crit_q;
    logic [CNT_W-1:0] req_cnt, pop_cnt, nwords;
    logic [OFS_W-1:0] req_ofs;
    logic             req_fire, last_pop, is_crit;

    assign nwords     = mode.single ? CNT_W'(1) : CNT_W'(LINE_WORDS);
    assign miss_ready = (state == LFU_IDLE);
    assign req_ofs    = crit_q + req_cnt[OFS_W-1:0];
    assign mem_req_valid = (state == LFU_FILL) && (req_cnt < nwords);
    assign mem_req_addr  = base_q | (ADDR_W'(req_ofs) << BYTE_W);
    assign req_fire   = mem_req_valid && mem_req_ready;

    assign is_crit    = (pop_cnt == '0);
    assign core_valid = (state == LFU_FILL) && q_valid && is_crit;
    assign q_pop      = (state == LFU_FILL) && q_valid && (!is_crit || core_ready);
    assign buf_we     = q_pop && !mode.single;
    assign buf_ofs    = crit_q + pop_cnt[OFS_W-1:0];
    assign last_pop   = q_pop && (pop_cnt == nwords - 1'b1);

    assign arr_we     = (state == LFU_WRITE);
    assign line_addr  = base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LFU_IDLE;
            mode    <= '0;
            base_q  <= '0;
            crit_q  <= '0;
            req_cnt <= '0;
            pop_cnt <= '0;
        end else begin
            case (state)
                LFU_IDLE: if (miss_valid) begin
                    state       <= LFU_FILL;
                    mode.single <= !cache_en;
                    mode.busy   <= 1'b1;
                    base_q      <= miss_addr & ~ADDR_W'((1 << LOW_W) - 1);
                    crit_q      <= miss_addr[BYTE_W +: OFS_W];
                    req_cnt     <= '0;
                    pop_cnt     <= '0;
                end
                LFU_FILL: begin
                    if (req_fire) req_cnt <= req_cnt + 1'b1;
                    if (q_pop)    pop_cnt <= pop_cnt + 1'b1;
                    if (last_pop) begin
                        state     <= mode.single ? LFU_IDLE : LFU_WRITE;
                        mode.busy <= !mode.single;
                    end
                end
                default: begin
                    state     <= LFU_IDLE;
                    mode.busy <= 1'b0;
                end
            endcase
        end
    end

    // R1
    req_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> (!mem_req_valid || req_ofs == OFS_W'($past(req_ofs) + 1'b1)));
    // R6
    write_once_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> (!arr_we && miss_ready));
    // R7
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.single && state == LFU_FILL) |-> (req_cnt <= CNT_W'(1)));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_ready && miss_valid) |=> !miss_ready);

endmodule

// File: rtl/line_fill_unit.sv
module line_fill_unit #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8,
    parameter int unsigned Q_DEPTH    = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cache_en,
    input  logic                         miss_valid,
    input  logic [ADDR_W-1:0]            miss_addr,
    output logic                         miss_ready,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [ADDR_W-1:0]            mem_req_addr,
    input  logic                         mem_rsp_valid,
    output logic                         mem_rsp_ready,
    input  logic [WORD_W-1:0]            mem_rsp_data,
    output logic                         core_valid,
    input  logic                         core_ready,
    output logic [WORD_W-1:0]            core_data,
    output logic                         arr_we,
    output logic [ADDR_W-1:0]            arr_addr,
    output logic [LINE_WORDS*WORD_W-1:0] arr_data,
    output logic [LINE_WORDS-1:0]        arr_parity,
    output logic                         arr_valid
);
    localparam int unsigned OFS_W = $clog2(LINE_WORDS);

    logic              q_valid, q_pop, buf_we;
    logic [WORD_W-1:0] q_data;
    logic [OFS_W-1:0]  buf_ofs;

    lfu_fifo2 #(.WIDTH(WORD_W), .DEPTH(Q_DEPTH)) i_queue (
        .clk(clk), .rst(rst),
        .in_valid(mem_rsp_valid), .in_ready(mem_rsp_ready), .in_data(mem_rsp_data),
        .pop(q_pop), .out_valid(q_valid), .out_data(q_data)
    );

    lfu_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) i_ctrl (
        .clk(clk), .rst(rst), .cache_en(cache_en),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .q_valid(q_valid), .q_pop(q_pop),
        .core_valid(core_valid), .core_ready(core_ready),
        .buf_we(buf_we), .buf_ofs(buf_ofs),
        .arr_we(arr_we), .line_addr(arr_addr)
    );

    lfu_line_buf #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) i_buf (
        .clk(clk), .we(buf_we), .ofs(buf_ofs), .wdata(q_data),
        .line_data(arr_data), .line_par(arr_parity)
    );

    assign core_data = q_data;
    assign arr_valid = arr_we;

    // R2
    core_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_valid && !core_ready) |=> (core_valid && $stable(core_data)));
    // R3
    rsp_full_chk: assert property (@(posedge clk) disable iff (rst)
        (core_valid && !core_ready && !mem_rsp_ready) |=> !mem_rsp_ready);

endmodule

// File: tb/test_line_fill_unit.sv
module test_line_fill_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         cache_en, miss_valid, miss_ready;
    logic [31:0]  miss_addr;
    logic         mem_req_valid, mem_req_ready;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid, mem_rsp_ready;
    logic [31:0]  mem_rsp_data;
    logic         core_valid, core_ready;
    logic [31:0]  core_data;
    logic         arr_we, arr_valid;
    logic [31:0]  arr_addr;
    logic [255:0] arr_data;
    logic [7:0]   arr_parity;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    line_fill_unit i_line_fill_unit (
        .clk(clk), .rst(rst), .cache_en(cache_en),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data),
        .core_valid(core_valid), .core_ready(core_ready), .core_data(core_data),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
        .arr_parity(arr_parity), .arr_valid(arr_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic run_fill(input logic [31:0] addr, input bit en, input int p);
        logic [31:0] pend [16];
        logic [31:0] base, exp_a, w;
        int ph = 0, pt = 0, nreq = 0, nrsp = 0, ncore = 0, nwe = 0, cyc = 0;
        int crit;
        base = addr & ~32'h1F;
        crit = int'(addr[4:2]);
        @(negedge clk);
        chk(miss_ready == 1'b1, "R8", "idle before miss", 32'(miss_ready), 32'd1);
        miss_valid = 1'b1; miss_addr = addr; cache_en = en;
        mem_rsp_valid = 1'b0; core_ready = 1'b0; mem_req_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (miss_ready) break;
            if (cyc > 300) begin
                chk(1'b0, "R8", "fill never ended", 32'(cyc), 32'd0);
                break;
            end
            miss_valid    = 1'b1;
            miss_addr     = addr ^ 32'h0000_0100;
            cache_en      = !en;
            mem_req_ready = (p == 1) ? cyc[0] : 1'b1;
            core_ready    = (p == 1) ? (cyc >= 6) : 1'b1;
            mem_rsp_valid = (ph != pt) && (p != 2 || (cyc % 3) != 0);
            mem_rsp_data  = (ph != pt) ? mdata(pend[ph]) : 32'h0;
            #1;
            chk(miss_ready == 1'b0, "R8", "busy during fill", 32'(miss_ready), 32'd0);
            if (p == 1 && ncore == 0)
                chk(mem_rsp_ready == (nrsp < 2), "R3", "queue room",
                    32'(mem_rsp_ready), 32'(nrsp < 2));
            if (mem_req_valid && mem_req_ready) begin
                exp_a = base | (32'((crit + nreq) % 8) << 2);
                chk(mem_req_addr == exp_a, en ? "R1" : "R7", "request address",
                    mem_req_addr, exp_a);
                pend[pt] = mem_req_addr;
                pt++; nreq++;
            end
            if (mem_rsp_valid && mem_rsp_ready) begin
                ph++; nrsp++;
            end
            if (core_valid) begin
                chk(core_data == mdata(addr & ~32'h3), "R2", "critical word",
                    core_data, mdata(addr & ~32'h3));
                if (core_ready) begin
                    chk(ncore == 0, "R2", "single core hand-off", 32'(ncore), 32'd0);
                    ncore++;
                end
            end
            if (arr_we) begin
                nwe++;
                chk(nrsp == 8, "R4", "all words in before write", 32'(nrsp), 32'd8);
                chk(arr_addr == base, "R4", "line address", arr_addr, base);
                chk(arr_valid == 1'b1, "R6", "valid with write", 32'(arr_valid), 32'd1);
                for (int i = 0; i < 8; i++) begin
                    w = mdata(base | (32'(i) << 2));
                    chk(arr_data[i*32 +: 32] == w, "R4", "line word",
                        arr_data[i*32 +: 32], w);
                    chk(arr_parity[i] == ^w, "R5", "word parity",
                        32'(arr_parity[i]), 32'(^w));
                end
            end
        end
        miss_valid = 1'b0; mem_rsp_valid = 1'b0;
        chk(nreq == (en ? 8 : 1), en ? "R1" : "R7", "request count", 32'(nreq), en ? 32'd8 : 32'd1);
        chk(nwe == (en ? 1 : 0), en ? "R6" : "R7", "array writes", 32'(nwe), en ? 32'd1 : 32'd0);
        chk(ncore == 1, "R2", "core hand-offs", 32'(ncore), 32'd1);
        chk(mem_req_valid == 1'b0, "R8", "no request after fill", 32'(mem_req_valid), 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cache_en = 1'b1; miss_valid = 1'b0; miss_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; core_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R9", "reset miss_ready", 32'(miss_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R9", "reset request", 32'(mem_req_valid), 32'd0);
        chk(core_valid == 1'b0, "R9", "reset core_valid", 32'(core_valid), 32'd0);
        chk(arr_we == 1'b0, "R9", "reset arr_we", 32'(arr_we), 32'd0);
        for (int p = 0; p < 3; p++) begin
            for (int e = 1; e >= 0; e--) begin
                for (int c = 0; c < 8; c++) begin
                    run_fill(32'h2000_0000 + 32'(p) * 32'h1000 + 32'(e) * 32'h400
                             + 32'(c) * 32'h24 + 32'(c % 4), e[0], p);
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule